// File: doc/BRIEF.md
# Mispredict Redirect Generator

This block looks at the results of one execute group, a fixed number of slots wide, and produces at most one front-end redirect per cycle. A slot can cause a redirect when it is valid, not squashed, and either mispredicted or executing while the load/store unit reports a memory-order violation. Slots are scanned from slot 0 upward. The lowest slot that can cause a redirect is the only one that acts in that group.

The redirect packet is registered and lasts one cycle. A branch redirect carries the branch PC, the corrected next PC and the actual direction. A memory redirect carries only the squash point and the restart PC, and it also raises a violation notification.

Two event counters run alongside the packet. One counts memory-order violation redirects. The other counts redirects from branches that had been predicted taken.

Top module: `redirect_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, every packet output, the violation notification and both counters are zero.
- R2: Slots are scanned from index 0 upward. Only the lowest-indexed slot that can cause a redirect produces the packet. Higher slots in the same group are ignored, including mispredicted ones.
- R3: When the selected slot is mispredicted and the violation input is also high, a branch redirect is produced. The violation notification stays 0 and the violation counter does not advance.
- R4: A branch redirect sets squash=1 and isBranch=1. It copies the slot's sequence number into redirSeq, its PC into redirMispredPc and its computed target into redirNextPc.
- R5: On a branch redirect, redirTaken is 1 exactly when the computed target differs from the slot PC plus 4.
- R6: A memory redirect comes from the lowest valid, non-squashed slot while the violation input is high. It sets squash=1, redirSeq and redirNextPc from that slot, and violationEvent=1. It leaves isBranch, redirTaken and redirMispredPc at 0.
- R7: A slot with valid=0 or squashed=1 never causes a redirect. If no other slot qualifies, no redirect is produced, even with the violation input high.
- R8: In a cycle with no redirect, squash, redirSeq, redirMispredPc, redirNextPc, isBranch, redirTaken and violationEvent are all 0.
- R9: The packet appears on the clock edge after the inputs that cause it. It holds for exactly one cycle unless the next group causes another redirect.
- R10: memViolCount increases by one on each cycle in which a memory redirect is output.
- R11: takenMispredCount increases by one on each branch redirect whose selected slot had predTaken=1. It does not change for other redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotValid | input | GROUP_W | Per-slot valid, bit i = slot i |
| slotSquashed | input | GROUP_W | Per-slot squashed flag |
| slotMispred | input | GROUP_W | Per-slot branch-mispredicted flag |
| slotPredTaken | input | GROUP_W | Per-slot predicted-taken flag |
| slotSeq | input | GROUP_W*SEQ_W | Sequence numbers, slot i at bits [i*SEQ_W +: SEQ_W] |
| slotPc | input | GROUP_W*PC_W | Slot PCs, slot i at bits [i*PC_W +: PC_W] |
| slotTarget | input | GROUP_W*PC_W | Computed targets, slot i at bits [i*PC_W +: PC_W] |
| memViolation | input | 1 | Memory-order violation reported for this group |
| redirSquash | output | 1 | Redirect valid / squash request |
| redirSeq | output | SEQ_W | Squash-point sequence number |
| redirMispredPc | output | PC_W | PC of the mispredicted branch |
| redirNextPc | output | PC_W | Restart PC |
| redirIsBranch | output | 1 | Redirect caused by branch misprediction |
| redirTaken | output | 1 | Actual branch direction |
| violationEvent | output | 1 | Memory-order violation redirect notification |
| memViolCount | output | CNT_W | Memory violation redirect count |
| takenMispredCount | output | CNT_W | Count of mispredicted predicted-taken branches |

## Verification
A branch misprediction and a memory-order violation can arrive in the same cycle. The bench produces this in two ways. In one, the violation input is raised together with a mispredicted slot 0. In the other, the violation input is raised with a plain slot 0 and a mispredicted slot 1. The first case must give a branch redirect with no violation notification and no change to the violation counter. The second must give a memory redirect from slot 0, with the later branch ignored. Both outcomes are judged from the packet fields and from the two counters read in the cycles that follow.

// File: rtl/redirect_gen_pkg.sv
package redirect_gen_pkg;
  // strobes from the selection control to the packet datapath
  typedef struct packed {
    logic fire;        // some slot produces a redirect this cycle
    logic branchSel;   // selected slot is a branch mispredict
    logic memSel;      // selected slot is a memory-order violation
    logic countTaken;  // selected branch had been predicted taken
  } redir_strobe_t;
endpackage

// File: rtl/redirect_ctrl.sv
module redirect_ctrl
  import redirect_gen_pkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] slotValid,
  input  logic [GROUP_W-1:0] slotSquashed,
  input  logic [GROUP_W-1:0] slotMispred,
  input  logic [GROUP_W-1:0] slotPredTaken,
  input  logic               memViolation,
  output logic [GROUP_W-1:0] selOnehot,
  output redir_strobe_t      strobe
);
  logic [GROUP_W-1:0] eligible;
  logic [GROUP_W-1:0] cause;

  genvar gi;
  generate
    for (gi = 0; gi < GROUP_W; gi++) begin : g_cause
      assign eligible[gi] = slotValid[gi] & ~slotSquashed[gi];
      assign cause[gi]    = eligible[gi] & (slotMispred[gi] | memViolation);
    end
  endgenerate

  // lowest-index causing slot wins
  always_comb begin
    logic found;
    found     = 1'b0;
    selOnehot = '0;
    for (int i = 0; i < GROUP_W; i++) begin
      if (cause[i] && !found) begin
        selOnehot[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  logic selMispred;
  logic selPredTaken;
  assign selMispred   = |(selOnehot & slotMispred);
  assign selPredTaken = |(selOnehot & slotPredTaken);

  always_comb begin
    strobe.fire       = |selOnehot;
    strobe.branchSel  = selMispred;
    strobe.memSel     = (|selOnehot) & ~selMispred;
    strobe.countTaken = selMispred & selPredTaken;
  end
endmodule

// File: rtl/redirect_datapath.sv
module redirect_datapath
  import redirect_gen_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int CNT_W      = 16,
  parameter int INST_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [GROUP_W-1:0]       selOnehot,
  input  redir_strobe_t            strobe,
  input  logic [GROUP_W*SEQ_W-1:0] slotSeq,
  input  logic [GROUP_W*PC_W-1:0]  slotPc,
  input  logic [GROUP_W*PC_W-1:0]  slotTarget,
  output logic                     redirSquash,
  output logic [SEQ_W-1:0]         redirSeq,
  output logic [PC_W-1:0]          redirMispredPc,
  output logic [PC_W-1:0]          redirNextPc,
  output logic                     redirIsBranch,
  output logic                     redirTaken,
  output logic                     violationEvent,
  output logic [CNT_W-1:0]         memViolCount,
  output logic [CNT_W-1:0]         takenMispredCount
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INST_BYTES);

  logic [SEQ_W-1:0] selSeq;
  logic [PC_W-1:0]  selPc;
  logic [PC_W-1:0]  selTarget;
  logic             actualTaken;

  // AND-OR mux over the one-hot select
  always_comb begin
    selSeq    = '0;
    selPc     = '0;
    selTarget = '0;
    for (int i = 0; i < GROUP_W; i++) begin
      if (selOnehot[i]) begin
        selSeq    = selSeq    | slotSeq[i*SEQ_W +: SEQ_W];
        selPc     = selPc     | slotPc[i*PC_W +: PC_W];
        selTarget = selTarget | slotTarget[i*PC_W +: PC_W];
      end
    end
  end

  assign actualTaken = (selTarget != (selPc + PC_STEP));

  always_ff @(posedge clk) begin
    if (rst) begin
      redirSquash       <= 1'b0;
      redirSeq          <= '0;
      redirMispredPc    <= '0;
      redirNextPc       <= '0;
      redirIsBranch     <= 1'b0;
      redirTaken        <= 1'b0;
      violationEvent    <= 1'b0;
      memViolCount      <= '0;
      takenMispredCount <= '0;
    end else begin
      redirSquash    <= strobe.fire;
      redirSeq       <= strobe.fire ? selSeq : '0;
      redirNextPc    <= strobe.fire ? selTarget : '0;
      redirMispredPc <= strobe.branchSel ? selPc : '0;
      redirIsBranch  <= strobe.branchSel;
      redirTaken     <= strobe.branchSel & actualTaken;
      violationEvent <= strobe.memSel;
      if (strobe.memSel)     memViolCount      <= memViolCount + 1'b1;
      if (strobe.countTaken) takenMispredCount <= takenMispredCount + 1'b1;
    end
  end
endmodule

// File: rtl/redirect_gen.sv
module redirect_gen
  import redirect_gen_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int CNT_W      = 16,
  parameter int INST_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [GROUP_W-1:0]       slotValid,
  input  logic [GROUP_W-1:0]       slotSquashed,
  input  logic [GROUP_W-1:0]       slotMispred,
  input  logic [GROUP_W-1:0]       slotPredTaken,
  input  logic [GROUP_W*SEQ_W-1:0] slotSeq,
  input  logic [GROUP_W*PC_W-1:0]  slotPc,
  input  logic [GROUP_W*PC_W-1:0]  slotTarget,
  input  logic                     memViolation,
  output logic                     redirSquash,
  output logic [SEQ_W-1:0]         redirSeq,
  output logic [PC_W-1:0]          redirMispredPc,
  output logic [PC_W-1:0]          redirNextPc,
  output logic                     redirIsBranch,
  output logic                     redirTaken,
  output logic                     violationEvent,
  output logic [CNT_W-1:0]         memViolCount,
  output logic [CNT_W-1:0]         takenMispredCount
);
  logic [GROUP_W-1:0] selOnehot;
  redir_strobe_t      strobe;

  redirect_ctrl #(.GROUP_W(GROUP_W)) u_ctrl (
    .slotValid    (slotValid),
    .slotSquashed (slotSquashed),
    .slotMispred  (slotMispred),
    .slotPredTaken(slotPredTaken),
    .memViolation (memViolation),
    .selOnehot    (selOnehot),
    .strobe       (strobe)
  );

  redirect_datapath #(
    .GROUP_W(GROUP_W), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .CNT_W(CNT_W), .INST_BYTES(INST_BYTES)
  ) u_dp (
    .clk              (clk),
    .rst              (rst),
    .selOnehot        (selOnehot),
    .strobe           (strobe),
    .slotSeq          (slotSeq),
    .slotPc           (slotPc),
    .slotTarget       (slotTarget),
    .redirSquash      (redirSquash),
    .redirSeq         (redirSeq),
    .redirMispredPc   (redirMispredPc),
    .redirNextPc      (redirNextPc),
    .redirIsBranch    (redirIsBranch),
    .redirTaken       (redirTaken),
    .violationEvent   (violationEvent),
    .memViolCount     (memViolCount),
    .takenMispredCount(takenMispredCount)
  );
endmodule

// File: rtl/redirect_gen_checker.sv
module redirect_gen_checker #(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             redirSquash,
  input logic [SEQ_W-1:0] redirSeq,
  input logic [PC_W-1:0]  redirMispredPc,
  input logic [PC_W-1:0]  redirNextPc,
  input logic             redirIsBranch,
  input logic             redirTaken,
  input logic             violationEvent,
  input logic [CNT_W-1:0] memViolCount,
  input logic [CNT_W-1:0] takenMispredCount
);
  // R3/R6: a redirect is either branch or memory, never both
  p_one_cause_r3: assert property (@(posedge clk) disable iff (rst)
    redirSquash |-> $countones({redirIsBranch, violationEvent}) == 1);

  // R4: branch flag implies squash
  p_branch_squash_r4: assert property (@(posedge clk) disable iff (rst)
    redirIsBranch |-> redirSquash);

  // R5: direction matches target vs fall-through
  p_taken_dir_r5: assert property (@(posedge clk) disable iff (rst)
    redirIsBranch |-> (redirTaken == (redirNextPc != redirMispredPc + PC_W'(4))));

  // R6: memory redirect carries no branch fields
  p_mem_fields_r6: assert property (@(posedge clk) disable iff (rst)
    violationEvent |-> (redirSquash && redirMispredPc == '0 && !redirTaken));

  // R8: idle cycle has zero packet
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !redirSquash |-> (redirSeq == '0 && redirMispredPc == '0 && redirNextPc == '0
                      && !redirIsBranch && !redirTaken && !violationEvent));

  // R10: violation counter moves only with a notification
  p_viol_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    !violationEvent |-> $stable(memViolCount));

  // R11: taken counter moves only on branch redirects
  p_taken_cnt_r11: assert property (@(posedge clk) disable iff (rst)
    !redirIsBranch |-> $stable(takenMispredCount));
endmodule

bind redirect_gen redirect_gen_checker #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .redirSquash      (redirSquash),
  .redirSeq         (redirSeq),
  .redirMispredPc   (redirMispredPc),
  .redirNextPc      (redirNextPc),
  .redirIsBranch    (redirIsBranch),
  .redirTaken       (redirTaken),
  .violationEvent   (violationEvent),
  .memViolCount     (memViolCount),
  .takenMispredCount(takenMispredCount)
);

// File: tb/tb_redirect_gen.sv
`timescale 1ns/1ps
module tb_redirect_gen;
  localparam int GROUP_W = 4;
  localparam int SEQ_W   = 16;
  localparam int PC_W    = 32;
  localparam int CNT_W   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [GROUP_W-1:0]       slotValid, slotSquashed, slotMispred, slotPredTaken;
  logic [GROUP_W*SEQ_W-1:0] slotSeq;
  logic [GROUP_W*PC_W-1:0]  slotPc, slotTarget;
  logic                     memViolation;
  logic                     redirSquash, redirIsBranch, redirTaken, violationEvent;
  logic [SEQ_W-1:0]         redirSeq;
  logic [PC_W-1:0]          redirMispredPc, redirNextPc;
  logic [CNT_W-1:0]         memViolCount, takenMispredCount;

  int checks = 0;
  int fails  = 0;
  int expViol = 0;
  int expTaken = 0;

  always #2.5 clk = ~clk;

  redirect_gen #(.GROUP_W(GROUP_W), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst),
    .slotValid(slotValid), .slotSquashed(slotSquashed), .slotMispred(slotMispred),
    .slotPredTaken(slotPredTaken), .slotSeq(slotSeq), .slotPc(slotPc),
    .slotTarget(slotTarget), .memViolation(memViolation),
    .redirSquash(redirSquash), .redirSeq(redirSeq), .redirMispredPc(redirMispredPc),
    .redirNextPc(redirNextPc), .redirIsBranch(redirIsBranch), .redirTaken(redirTaken),
    .violationEvent(violationEvent), .memViolCount(memViolCount),
    .takenMispredCount(takenMispredCount)
  );

  task automatic clearInputs();
    slotValid = '0; slotSquashed = '0; slotMispred = '0; slotPredTaken = '0;
    slotSeq = '0; slotPc = '0; slotTarget = '0; memViolation = 1'b0;
  endtask

  task automatic setSlot(input int i, input logic v, input logic sq, input logic mp,
                         input logic pt, input logic [SEQ_W-1:0] seq,
                         input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt);
    slotValid[i] = v; slotSquashed[i] = sq; slotMispred[i] = mp; slotPredTaken[i] = pt;
    slotSeq[i*SEQ_W +: SEQ_W] = seq;
    slotPc[i*PC_W +: PC_W] = pc;
    slotTarget[i*PC_W +: PC_W] = tgt;
  endtask

  task automatic checkVal(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkPkt(input string req, input logic sq, input logic [SEQ_W-1:0] seq,
                          input logic [PC_W-1:0] mpc, input logic [PC_W-1:0] npc,
                          input logic br, input logic tk, input logic viol);
    checkVal(req, "squash",   64'(redirSquash),    64'(sq));
    checkVal(req, "seq",      64'(redirSeq),       64'(seq));
    checkVal(req, "mispredPc",64'(redirMispredPc), 64'(mpc));
    checkVal(req, "nextPc",   64'(redirNextPc),    64'(npc));
    checkVal(req, "isBranch", 64'(redirIsBranch),  64'(br));
    checkVal(req, "taken",    64'(redirTaken),     64'(tk));
    checkVal(req, "violEvt",  64'(violationEvent), 64'(viol));
  endtask

  task automatic checkCounters(input string req);
    checkVal(req, "memViolCount",      64'(memViolCount),      64'(expViol));
    checkVal(req, "takenMispredCount", 64'(takenMispredCount), 64'(expTaken));
  endtask

  // apply the staged group for one cycle, sample after the edge
  task automatic applyGroup();
    @(posedge clk); #1;
  endtask

  // R9: next cycle with empty group gives a zero packet
  task automatic drainCheck();
    @(negedge clk); clearInputs();
    @(posedge clk); #1;
    checkPkt("R9", 0, 0, 0, 0, 0, 0, 0);
    checkCounters("R9");
  endtask

  task automatic testReset();
    checkPkt("R1", 0, 0, 0, 0, 0, 0, 0);
    checkCounters("R1");
  endtask

  task automatic testBranchTaken();
    @(negedge clk); clearInputs();
    setSlot(0, 1, 0, 0, 0, 16'd10, 32'h100, 32'h104);
    setSlot(2, 1, 0, 1, 0, 16'd12, 32'h1000, 32'h2000);
    applyGroup();
    checkPkt("R4", 1, 16'd12, 32'h1000, 32'h2000, 1, 1, 0); // R5 taken
    checkCounters("R11");
    drainCheck();
  endtask

  task automatic testBranchNotTaken();
    @(negedge clk); clearInputs();
    setSlot(1, 1, 0, 1, 1, 16'd33, 32'h4000, 32'h4004);
    applyGroup();
    expTaken++;
    checkPkt("R5", 1, 16'd33, 32'h4000, 32'h4004, 1, 0, 0);
    checkCounters("R11");
    drainCheck();
  endtask

  task automatic testFirstWins();
    @(negedge clk); clearInputs();
    setSlot(0, 1, 0, 0, 0, 16'd40, 32'h500, 32'h504);
    setSlot(1, 1, 0, 1, 0, 16'd41, 32'h504, 32'h800);
    setSlot(3, 1, 0, 1, 1, 16'd43, 32'h50c, 32'h900);
    applyGroup();
    checkPkt("R2", 1, 16'd41, 32'h504, 32'h800, 1, 1, 0);
    checkCounters("R11");
    drainCheck();
  endtask

  task automatic testSquashedSkipped();
    @(negedge clk); clearInputs();
    setSlot(0, 1, 1, 1, 1, 16'd50, 32'h600, 32'h700);
    setSlot(1, 0, 0, 1, 1, 16'd51, 32'h604, 32'h710);
    setSlot(2, 1, 0, 1, 1, 16'd52, 32'h608, 32'h60c);
    applyGroup();
    expTaken++;
    checkPkt("R7", 1, 16'd52, 32'h608, 32'h60c, 1, 0, 0);
    checkCounters("R7");
    drainCheck();
  endtask

  task automatic testViolation();
    @(negedge clk); clearInputs();
    memViolation = 1'b1;
    setSlot(0, 0, 0, 0, 0, 16'd60, 32'ha00, 32'hb00);
    setSlot(1, 1, 1, 0, 0, 16'd61, 32'ha04, 32'hb04);
    setSlot(2, 1, 0, 0, 1, 16'd62, 32'ha08, 32'hc00);
    setSlot(3, 1, 0, 1, 1, 16'd63, 32'ha0c, 32'hd00);
    applyGroup();
    expViol++;
    checkPkt("R6", 1, 16'd62, 0, 32'hc00, 0, 0, 1);
    checkCounters("R10");
    drainCheck();
  endtask

  task automatic testBranchOverViolation();
    @(negedge clk); clearInputs();
    memViolation = 1'b1;
    setSlot(0, 1, 0, 1, 1, 16'd70, 32'hc00, 32'he00);
    applyGroup();
    expTaken++;
    checkPkt("R3", 1, 16'd70, 32'hc00, 32'he00, 1, 1, 0);
    checkCounters("R3");
    drainCheck();
  endtask

  task automatic testViolationBeforeLaterBranch();
    @(negedge clk); clearInputs();
    memViolation = 1'b1;
    setSlot(0, 1, 0, 0, 0, 16'd80, 32'hf00, 32'hf04);
    setSlot(1, 1, 0, 1, 1, 16'd81, 32'hf04, 32'h1f00);
    applyGroup();
    expViol++;
    checkPkt("R2", 1, 16'd80, 0, 32'hf04, 0, 0, 1);
    checkCounters("R10");
    drainCheck();
  endtask

  task automatic testIdle();
    @(negedge clk); clearInputs();
    setSlot(0, 1, 0, 0, 1, 16'd90, 32'h100, 32'h300);
    setSlot(1, 1, 0, 0, 0, 16'd91, 32'h104, 32'h108);
    applyGroup();
    checkPkt("R8", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); clearInputs();
    memViolation = 1'b1;
    setSlot(0, 1, 1, 0, 0, 16'd92, 32'h200, 32'h204);
    setSlot(2, 0, 0, 1, 0, 16'd93, 32'h208, 32'h400);
    applyGroup();
    checkPkt("R7", 0, 0, 0, 0, 0, 0, 0);
    checkCounters("R7");
    drainCheck();
  endtask

  task automatic testBackToBack();
    @(negedge clk); clearInputs();
    setSlot(3, 1, 0, 1, 1, 16'd100, 32'h2000, 32'h3000);
    applyGroup();
    expTaken++;
    checkPkt("R9", 1, 16'd100, 32'h2000, 32'h3000, 1, 1, 0);
    @(negedge clk); clearInputs();
    memViolation = 1'b1;
    setSlot(1, 1, 0, 0, 0, 16'd101, 32'h2004, 32'h2008);
    applyGroup();
    expViol++;
    checkPkt("R9", 1, 16'd101, 0, 32'h2008, 0, 0, 1);
    checkCounters("R10");
    drainCheck();
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clearInputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    testReset();
    testBranchTaken();
    testBranchNotTaken();
    testFirstWins();
    testSquashedSkipped();
    testViolation();
    testBranchOverViolation();
    testViolationBeforeLaterBranch();
    testIdle();
    testBackToBack();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule